// File: doc/BRIEF.md
# Multi-CPU Interrupt Enable and Acknowledge Controller

This block gathers level-sensitive interrupt lines from peripherals and presents them to a small cluster of processors. Software controls it through one register bus that reaches two windows. The shared window holds the global enable of every source, a read-only control word that reports the number of sources, and one routing register per source. The per-CPU window holds that CPU's private mask and its acknowledge register. The CPU making an access is named on `bus_cpu`.

Enable and mask bits are not written as bitmaps. Software writes a source number to a set register or to a clear register, so no read-modify-write sequence is needed and two CPUs cannot race on a shared word. A source is pending for a CPU when its line is high and its gates are open. The acknowledge read returns the lowest-numbered pending source, or the code 1023 when nothing is pending. Sources flagged by a parameter as per-CPU (a private timer, for example) are gated only by each CPU's mask. Each CPU also has a summary line, `cpu_irq`, that is high whenever its acknowledge read would return a valid number.

Top module: `intc_ctrl`

## Requirements
- R1: After reset every source is globally disabled, every source is masked on every CPU, every routing register holds 1 (CPU 0 only), every `cpu_irq` bit is low and every acknowledge read returns 1023.
- R2: A read of shared offset 0x000 returns NUM_SRC in bits [11:2], with all other bits zero.
- R3: Writing n to shared offset 0x030 sets the global enable of source n, and writing n to shared offset 0x034 clears it. The number is taken from write-data bits [9:0], and a number n >= NUM_SRC changes nothing.
- R4: Writing n to per-CPU offset 0x048 masks source n for the CPU named on `bus_cpu`, and writing n to per-CPU offset 0x04C unmasks it. No other CPU's mask changes.
- R5: The routing register of source n sits at shared offset 0x100 + 4*n. Bit c of that register routes the source to CPU c. The register stores and returns NUM_CPU bits, and the upper bits read as zero.
- R6: A shared source n is pending for CPU c exactly when `src_in[n]` is high, its global enable is set, routing bit c is set and CPU c's mask bit for n is clear.
- R7: A source flagged in PERCPU_SRCS is pending for CPU c when its input is high and CPU c's mask bit is clear. Its global enable and its routing register are ignored.
- R8: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source pending for the accessing CPU, or 1023 when none is pending. Bits [31:10] are zero.
- R9: `cpu_irq[c]` is high in the same cycle that any source is pending for CPU c, and low otherwise.
- R10: Read data appears on `bus_rdata` in the cycle after the read is accepted and holds until the next read. Reads change no state, so an acknowledge read repeated with unchanged inputs returns the same number. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_local | input | 1 | 1 selects the per-CPU window, 0 the shared window |
| bus_cpu | input | CPU_W | Number of the accessing CPU |
| bus_addr | input | 12 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | NUM_SRC | Level-sensitive interrupt inputs |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request summary |

## Verification
A wrong enable, mask or routing bit shows up in two places. The affected CPU's `cpu_irq` changes in the same cycle, and the acknowledge read issued in the next cycle returns a different number, so the bench compares both against a model after every operation. A priority encoder that scans in the wrong direction, or that mishandles the empty case, returns a number other than the lowest pending one or other than 1023. These faults appear one cycle after the read is accepted. Mask writes that leak between CPUs are caught by reading the acknowledge of every CPU, not only the one that wrote.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ACK_NONE = 10'h3FF;

  localparam logic [11:0] OFS_CTRL       = 12'h000;
  localparam logic [11:0] OFS_EN_SET     = 12'h030;
  localparam logic [11:0] OFS_EN_CLR     = 12'h034;
  localparam logic [11:0] OFS_ACK        = 12'h044;
  localparam logic [11:0] OFS_MASK_SET   = 12'h048;
  localparam logic [11:0] OFS_MASK_CLR   = 12'h04C;
  localparam logic [11:0] OFS_ROUTE_BASE = 12'h100;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic msk_set;
    logic msk_clr;
    logic route_wr;
  } wr_op_t;
endpackage

// File: rtl/intc_first_set.sv
`timescale 1ns/1ps
module intc_first_set
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    req,
  output logic [ID_W-1:0] id,
  output logic            any
);
  always_comb begin
    id = ACK_NONE;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) id = ID_W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/intc_gate_state.sv
`timescale 1ns/1ps
module intc_gate_state
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  wr_op_t                            op,
  input  logic [CPU_W-1:0]                  op_cpu,
  input  logic [ID_W-1:0]                   op_idx,
  input  logic [ID_W-1:0]                   route_idx,
  input  logic [NUM_CPU-1:0]                route_val,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);
  logic [NUM_SRC-1:0]              en_d;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_d;
  logic                            state_ce;

  assign state_ce = |op;

  always_comb begin
    en_d    = en_q;
    mask_d  = mask_q;
    route_d = route_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (op_idx == ID_W'(s)) begin
        if (op.en_set) en_d[s] = 1'b1;
        if (op.en_clr) en_d[s] = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
          if (op_cpu == CPU_W'(c)) begin
            if (op.msk_set) mask_d[c][s] = 1'b1;
            if (op.msk_clr) mask_d[c][s] = 1'b0;
          end
        end
      end
      if (op.route_wr && (route_idx == ID_W'(s))) route_d[s] = route_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '1;
      for (int s = 0; s < NUM_SRC; s++) route_q[s] <= NUM_CPU'(1);
    end else if (state_ce) begin
      en_q    <= en_d;
      mask_q  <= mask_d;
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 NUM_CPU     = 4,
  parameter logic [NUM_SRC-1:0] PERCPU_SRCS = NUM_SRC'(32'h0000_0020),
  localparam int                CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_local,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int ROUTE_END = 256 + 4 * NUM_SRC;

  logic                            cpu_ok, in_route, wr_acc, rd_acc;
  logic [ID_W-1:0]                 route_idx;
  wr_op_t                          op;
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack_id;
  logic [31:0]                     rdata_d, rdata_q;
  logic [11:0]                     route_ofs;

  assign cpu_ok    = (32'(bus_cpu) < NUM_CPU);
  assign wr_acc    = bus_valid && bus_write;
  assign rd_acc    = bus_valid && !bus_write;
  assign route_ofs = bus_addr - OFS_ROUTE_BASE;
  assign route_idx = ID_W'(route_ofs >> 2);
  assign in_route  = (bus_addr >= OFS_ROUTE_BASE) && (32'(bus_addr) < ROUTE_END)
                     && (bus_addr[1:0] == 2'b00);

  always_comb begin
    op          = '0;
    op.en_set   = wr_acc && !bus_local && (bus_addr == OFS_EN_SET);
    op.en_clr   = wr_acc && !bus_local && (bus_addr == OFS_EN_CLR);
    op.route_wr = wr_acc && !bus_local && in_route;
    op.msk_set  = wr_acc && bus_local && cpu_ok && (bus_addr == OFS_MASK_SET);
    op.msk_clr  = wr_acc && bus_local && cpu_ok && (bus_addr == OFS_MASK_CLR);
  end

  intc_gate_state #(
    .NUM_SRC(NUM_SRC),
    .NUM_CPU(NUM_CPU)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .op_cpu   (bus_cpu),
    .op_idx   (bus_wdata[ID_W-1:0]),
    .route_idx(route_idx),
    .route_val(bus_wdata[NUM_CPU-1:0]),
    .en_q     (en_q),
    .mask_q   (mask_q),
    .route_q  (route_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (PERCPU_SRCS[s]) begin : g_private
        assign pend[c][s] = src_in[s] && !mask_q[c][s];
      end else begin : g_shared
        assign pend[c][s] = src_in[s] && !mask_q[c][s] && en_q[s] && route_q[s][c];
      end
    end
    intc_first_set #(.W(NUM_SRC)) u_enc (
      .req(pend[c]),
      .id (ack_id[c]),
      .any(cpu_irq[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (!bus_local) begin
      if (bus_addr == OFS_CTRL) begin
        rdata_d[11:2] = 10'(NUM_SRC);
      end else if (in_route) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (route_idx == ID_W'(s)) rdata_d[NUM_CPU-1:0] = route_q[s];
        end
      end
    end else if (cpu_ok && (bus_addr == OFS_ACK)) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (bus_cpu == CPU_W'(c)) rdata_d[ID_W-1:0] = ack_id[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/intc_ctrl_chk.sv
`timescale 1ns/1ps
module intc_ctrl_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_valid,
  input logic                            bus_write,
  input logic                            bus_local,
  input logic [CPU_W-1:0]                bus_cpu,
  input logic [11:0]                     bus_addr,
  input logic [31:0]                     bus_wdata,
  input logic [31:0]                     bus_rdata,
  input logic [NUM_SRC-1:0]              src_in,
  input logic [NUM_CPU-1:0]              cpu_irq,
  input logic [NUM_SRC-1:0]              en_q,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q
);
  logic             ack_rd, ctrl_rd, idx_ok;
  logic [SRC_W-1:0] idx_q;
  logic [CPU_W-1:0] cpu_q;

  assign ack_rd  = bus_valid && !bus_write && bus_local && (bus_addr == OFS_ACK)
                   && (32'(bus_cpu) < NUM_CPU);
  assign ctrl_rd = bus_valid && !bus_write && !bus_local && (bus_addr == OFS_CTRL);
  assign idx_ok  = (bus_wdata[31:ID_W] == '0) && (32'(bus_wdata[ID_W-1:0]) < NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cpu_q <= '0;
    end else begin
      idx_q <= bus_wdata[SRC_W-1:0];
      cpu_q <= bus_cpu;
    end
  end

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in == '0) |-> (cpu_irq == '0));

  // R8
  ack_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !cpu_irq[bus_cpu]) |=> (bus_rdata == 32'h3FF));

  // R8
  ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && cpu_irq[bus_cpu]) |=> (bus_rdata < NUM_SRC));

  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (bus_rdata == (32'(NUM_SRC) << 2)));

  // R3
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_local && (bus_addr == OFS_EN_CLR) && idx_ok)
    |=> !en_q[idx_q]);

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_local && (bus_addr == OFS_MASK_SET) && idx_ok
     && (32'(bus_cpu) < NUM_CPU))
    |=> mask_q[cpu_q][idx_q]);
endmodule

bind intc_ctrl intc_ctrl_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_CPU(NUM_CPU)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_local(bus_local),
  .bus_cpu  (bus_cpu),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .src_in   (src_in),
  .cpu_irq  (cpu_irq),
  .en_q     (en_q),
  .mask_q   (mask_q)
);

// File: tb/intc_ctrl_bench.sv
`timescale 1ns/1ps
module intc_ctrl_bench;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam logic [31:0] PRIV = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_local = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_in = '0;
  logic [NC-1:0] cpu_irq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  bit       m_en   [NS];
  bit       m_mask [NC][NS];
  bit [3:0] m_route[NS];

  always #2 clk = ~clk;

  intc_ctrl #(.NUM_SRC(NS), .NUM_CPU(NC), .PERCPU_SRCS(PRIV)) u_intc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .cpu_irq(cpu_irq));

  function automatic bit pend(int c, int s);
    if (!src_in[s] || m_mask[c][s]) return 1'b0;
    if (PRIV[s]) return 1'b1;
    return m_en[s] && m_route[s][c];
  endfunction

  function automatic logic [31:0] exp_ack(int c);
    for (int s = 0; s < NS; s++) if (pend(c, s)) return 32'(s);
    return 32'h3FF;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = (exp_ack(c) != 32'h3FF);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(bit loc, int cpu, logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_local = loc;
    bus_cpu = 2'(cpu); bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (!loc && addr == 12'h030 && data < NS) m_en[data] = 1'b1;
    if (!loc && addr == 12'h034 && data < NS) m_en[data] = 1'b0;
    if (loc && addr == 12'h048 && data < NS) m_mask[cpu][data] = 1'b1;
    if (loc && addr == 12'h04C && data < NS) m_mask[cpu][data] = 1'b0;
    if (!loc && addr >= 12'h100 && addr < 12'h100 + 4 * NS && addr[1:0] == 2'b00)
      m_route[(addr - 12'h100) >> 2] = data[3:0];
  endtask

  task automatic bus_rd(bit loc, int cpu, logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_local = loc;
    bus_cpu = 2'(cpu); bus_addr = addr;
    @(negedge clk);
    bus_valid = 1'b0;
    data = bus_rdata;
  endtask

  task automatic check_all_acks(string req);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      bus_rd(1'b1, c, 12'h044, d);
      check(req, d, exp_ack(c));
    end
    check({req, " irq"}, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin
      m_en[s] = 1'b0; m_route[s] = 4'b0001;
      for (int c = 0; c < NC; c++) m_mask[c][s] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state with every input high
    src_in = '1;
    @(negedge clk);
    check_all_acks("R1");
    bus_rd(1'b0, 0, 12'h100 + 12'd4 * 12'd7, d);
    check("R1 route", d, 32'h1);

    // R2: control word
    bus_rd(1'b0, 0, 12'h000, d);
    check("R2", d, 32'(NS) << 2);

    // R3 and R6: enable source 3, unmask on CPU 0 only
    bus_wr(1'b0, 0, 12'h030, 32'd3);
    bus_wr(1'b1, 0, 12'h04C, 32'd3);
    check_all_acks("R6");
    // R3: out-of-range number is ignored
    bus_wr(1'b0, 0, 12'h034, 32'd40);
    check_all_acks("R3");
    // R4: unmask on CPU 1 while routed to CPU 0 only
    bus_wr(1'b1, 1, 12'h04C, 32'd3);
    check_all_acks("R4");
    // R5: reroute source 3 to CPU 1
    bus_wr(1'b0, 0, 12'h10C, 32'hFFFF_FFF2);
    bus_rd(1'b0, 0, 12'h10C, d);
    check("R5", d, 32'h2);
    check_all_acks("R5");
    // R7: private source 5, never enabled, unmasked on CPU 2 and CPU 0
    bus_wr(1'b1, 2, 12'h04C, 32'd5);
    bus_wr(1'b1, 0, 12'h04C, 32'd5);
    check_all_acks("R7");
    // R8: lower number wins, then falls back when its line drops
    bus_wr(1'b0, 0, 12'h030, 32'd2);
    bus_wr(1'b1, 0, 12'h04C, 32'd2);
    check_all_acks("R8");
    src_in[2] = 1'b0;
    @(negedge clk);
    check_all_acks("R8");
    // R10: repeated acknowledge read, unmapped read
    bus_rd(1'b1, 0, 12'h044, d);
    bus_rd(1'b1, 0, 12'h044, d2);
    check("R10", d2, d);
    bus_rd(1'b0, 0, 12'h200, d);
    check("R10", d, 32'h0);
    // R3: clear enable of source 3, CPU 1 loses it
    bus_wr(1'b0, 0, 12'h034, 32'd3);
    check_all_acks("R3");
    // R9: all lines low
    src_in = '0;
    @(negedge clk);
    check("R9", 32'(cpu_irq), 32'h0);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op  = $urandom_range(0, 5);
      int cpu = $urandom_range(0, NC - 1);
      int n   = $urandom_range(0, NS + 7);
      case (op)
        0: bus_wr(1'b0, cpu, 12'h030, 32'(n));
        1: bus_wr(1'b0, cpu, 12'h034, 32'(n));
        2: bus_wr(1'b1, cpu, 12'h048, 32'(n));
        3: bus_wr(1'b1, cpu, 12'h04C, 32'(n));
        4: bus_wr(1'b0, cpu, 12'h100 + 12'(4 * (n % NS)), $urandom());
        default: begin
          src_in = $urandom();
          @(negedge clk);
        end
      endcase
      bus_rd(1'b1, cpu, 12'h044, d);
      check("R8 random", d, exp_ack(cpu));
      check("R9 random", 32'(cpu_irq), 32'(exp_irq()));
    end
    check_all_acks("R6 final");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule